// File: doc/BRIEF.md
# Bus Reset Trigger and Watchdog

This block decides when a bus-repeater node has to begin a bus reset. Eight sources can ask for one. Each cycle the block samples them, folds them into a single trigger and drives the node through a fixed sequence: a reset-drive phase of fixed length, then tree identification, then self identification, then normal operation. Each time a trigger is accepted, a registered cause code records which source won.

Some sources act at once:

- power-up
- a reset heard on the arbitration lines of a connected port
- a link-layer request
- a resume event
- a suspend entered because the peer went away

Two sources are conditional. Loss of bias counts only on the port that is currently the parent. A new connection fires only after a programmable delay, and that delay is abandoned if a reset arrives from the far side first. A watchdog watches the arbitration state code and forces a reset when any state outside four exempt ones lasts longer than a time limit. The limit is set in microseconds and converted to cycles from the clock frequency.

Top module: `brst_trigger`

## Requirements
- R1: While `rst_n` is low, `reset_drive`=0, `phase`=0 and `cause`=0. At the first rising edge after release, the block enters the reset phase (`phase`=1) with `cause`=1 (power-up).
- R2: A high `port_arb_reset[i]` on a port whose `port_connected[i]` is high starts a reset with `cause`=2. The same input on a port that is not connected has no effect.
- R3: A high `link_reset_req` starts a reset with `cause`=3.
- R4: A high `resume_evt` starts a reset with `cause`=4.
- R5: Bias loss starts a reset with `cause`=5 when `port_bias` falls (1 to 0 between two edges) on the port selected by `parent_port` while `parent_valid` is high. A fall on any other port, or a fall while `parent_valid` is low, has no effect.
- R6: A high `peer_suspend_evt` starts a reset with `cause`=6.
- R7: When `port_connected[i]` rises and is first sampled at edge t, the reset (`cause`=7) is entered at edge t+CONN_DLY. The pending connect reset is dropped if a connected port reports an arbitration reset before it fires, or if the port disconnects.
- R8: When `arb_state` holds one value outside {ST_IDLE, ST_TSTART, ST_TX, ST_RX} at CLK_MHZ*WD_US+1 consecutive edges, a reset with `cause`=8 is entered at the last of those edges. One edge fewer does not trigger. A change of value restarts the count, and the four exempt codes never trigger.
- R9: When several sources are active in the same cycle, `cause` takes the smallest code among them.
- R10: The reset phase (`phase`=1, `reset_drive`=1) lasts RESET_CYC cycles and then moves to tree identification (`phase`=2). A `tree_done` pulse moves it to self identification (`phase`=3), and a `self_done` pulse returns it to normal (`phase`=0).
- R11: A trigger in any phase, including the reset phase itself, restarts a full-length reset phase and updates `cause`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| port_connected | input | NPORT | Per-port connection level; a rising edge is a connect event |
| port_arb_reset | input | NPORT | Per-port reset sensed on the arbitration lines |
| port_bias | input | NPORT | Per-port bias-present status |
| parent_valid | input | 1 | A parent port exists |
| parent_port | input | PW | Index of the parent port |
| link_reset_req | input | 1 | Reset request from the link layer |
| resume_evt | input | 1 | Resume from suspend |
| peer_suspend_evt | input | 1 | Suspend entered because the peer suspended or was disabled |
| arb_state | input | SW | Current arbitration state code |
| tree_done | input | 1 | Tree identification finished |
| self_done | input | 1 | Self identification finished |
| reset_drive | output | 1 | Request to drive bus reset on the ports |
| phase | output | 2 | 0 normal, 1 reset, 2 tree identification, 3 self identification |
| cause | output | 4 | Code of the last accepted trigger (0 = none yet) |

## Verification
Some properties are checked on every cycle:

- Any trigger leads to the reset phase on the next edge, with the encoded cause.
- The phase only ever steps from reset to tree identification, and from tree to self identification.
- The watchdog counter clears on a state change or an exempt state.
- A pending connect delay disappears once it is cancelled or has fired.

The bench scenarios cover what the properties cannot:

- the exact latency of the connect delay and of the watchdog
- the sweep over all sixteen state codes
- the pairwise priority results
- the sources that must have no effect, such as an unconnected port or a non-parent bias loss

// File: rtl/brst_pkg.sv
package brst_pkg;

  typedef enum logic [1:0] {
    PH_NORMAL = 2'd0,
    PH_RESET  = 2'd1,
    PH_TREE   = 2'd2,
    PH_SELF   = 2'd3
  } phase_e;

  localparam int NCAUSE = 8;
  localparam int CAUSE_W = 4;

  localparam logic [CAUSE_W-1:0] C_NONE    = 4'd0;
  localparam logic [CAUSE_W-1:0] C_POWER   = 4'd1;
  localparam logic [CAUSE_W-1:0] C_ARB     = 4'd2;
  localparam logic [CAUSE_W-1:0] C_LINK    = 4'd3;
  localparam logic [CAUSE_W-1:0] C_RESUME  = 4'd4;
  localparam logic [CAUSE_W-1:0] C_BIAS    = 4'd5;
  localparam logic [CAUSE_W-1:0] C_SUSPEND = 4'd6;
  localparam logic [CAUSE_W-1:0] C_CONNECT = 4'd7;
  localparam logic [CAUSE_W-1:0] C_WDOG    = 4'd8;

  // cycles in the watchdog window for a clock in MHz and a limit in microseconds
  function automatic int wd_limit(input int clk_mhz, input int lim_us);
    return clk_mhz * lim_us;
  endfunction

  // smallest active code wins; bit i of hits stands for code i+1
  function automatic logic [CAUSE_W-1:0] pick_cause(input logic [NCAUSE-1:0] hits);
    logic [CAUSE_W-1:0] code;
    code = C_NONE;
    for (int i = NCAUSE - 1; i >= 0; i--) begin
      if (hits[i]) code = CAUSE_W'(i + 1);
    end
    return code;
  endfunction

endpackage

// File: rtl/brst_cause_pri.sv
module brst_cause_pri
  import brst_pkg::*;
(
  input  logic [NCAUSE-1:0]  hits,
  output logic [CAUSE_W-1:0] code,
  output logic               any_hit
);

  assign code    = pick_cause(hits);
  assign any_hit = |hits;

  // R9: the chosen code names an active source and no lower one is active
  always_comb begin
    if (any_hit) begin
      a_pri_valid_r9 : assert (code != C_NONE && hits[code - 1'b1]);
      a_pri_lowest_r9 : assert ((hits & ((NCAUSE'(1) << (code - 1'b1)) - NCAUSE'(1))) == '0);
    end
  end

endmodule

// File: rtl/brst_conn_delay.sv
module brst_conn_delay #(
  parameter int CONN_DLY = 64,
  localparam int CW = $clog2(CONN_DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic connected,
  input  logic cancel,
  output logic fire
);

  logic          conn_q;
  logic          active;
  logic [CW-1:0] remain;
  logic          rise;

  assign rise = connected & ~conn_q;
  assign fire = active && (remain == CW'(1)) && connected && !cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      active <= 1'b0;
      remain <= '0;
    end else begin
      conn_q <= connected;
      if (cancel || !connected) begin
        active <= 1'b0;
      end else if (rise) begin
        active <= 1'b1;
        remain <= CW'(CONN_DLY);
      end else if (active) begin
        if (remain == CW'(1)) active <= 1'b0;
        else                  remain <= remain - 1'b1;
      end
    end
  end

  // R7: a cancel or a disconnect drops any pending connect reset
  p_conn_cancel_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (cancel || !connected) |=> !active);

  // R7: a fired connect reset is not repeated
  p_conn_once_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !active);

endmodule

// File: rtl/brst_watchdog.sv
module brst_watchdog #(
  parameter int SW       = 4,
  parameter int CLK_MHZ  = 200,
  parameter int WD_US    = 300,
  parameter logic [SW-1:0] ST_IDLE   = 4'd0,
  parameter logic [SW-1:0] ST_TSTART = 4'd1,
  parameter logic [SW-1:0] ST_TX     = 4'd2,
  parameter logic [SW-1:0] ST_RX     = 4'd3,
  localparam int LIMIT = brst_pkg::wd_limit(CLK_MHZ, WD_US),
  localparam int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] arb_state,
  output logic          wd_fire
);

  logic [SW-1:0] prev_state;
  logic [CW-1:0] dwell;
  logic          exempt;
  logic          same;

  assign exempt  = (arb_state == ST_IDLE) || (arb_state == ST_TSTART) ||
                   (arb_state == ST_TX)   || (arb_state == ST_RX);
  assign same    = (arb_state == prev_state);
  assign wd_fire = !exempt && same && (dwell == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_state <= ST_IDLE;
      dwell      <= '0;
    end else begin
      prev_state <= arb_state;
      if (exempt || !same)          dwell <= '0;
      else if (dwell != CW'(LIMIT)) dwell <= dwell + 1'b1;
    end
  end

  // R8: exempt states and state changes restart the window
  p_wd_exempt_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (exempt || !same) |=> dwell == '0);

  // R8: the watchdog never fires in an exempt state
  p_wd_no_exempt_fire_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    exempt |-> !wd_fire);

endmodule

// File: rtl/brst_trigger.sv
module brst_trigger
  import brst_pkg::*;
#(
  parameter int NPORT     = 3,
  parameter int SW        = 4,
  parameter int CONN_DLY  = 64,
  parameter int CLK_MHZ   = 200,
  parameter int WD_US     = 300,
  parameter int RESET_CYC = 32,
  parameter logic [SW-1:0] ST_IDLE   = 4'd0,
  parameter logic [SW-1:0] ST_TSTART = 4'd1,
  parameter logic [SW-1:0] ST_TX     = 4'd2,
  parameter logic [SW-1:0] ST_RX     = 4'd3,
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] port_connected,
  input  logic [NPORT-1:0] port_arb_reset,
  input  logic [NPORT-1:0] port_bias,
  input  logic             parent_valid,
  input  logic [PW-1:0]    parent_port,
  input  logic             link_reset_req,
  input  logic             resume_evt,
  input  logic             peer_suspend_evt,
  input  logic [SW-1:0]    arb_state,
  input  logic             tree_done,
  input  logic             self_done,
  output logic             reset_drive,
  output logic [1:0]       phase,
  output logic [3:0]       cause
);

  localparam int RCW = (RESET_CYC > 1) ? $clog2(RESET_CYC) : 1;

  phase_e             ph_q;
  logic [RCW-1:0]     rcnt;
  logic [CAUSE_W-1:0] cause_q;
  logic               pwr_pend;
  logic [NPORT-1:0]   bias_q;
  logic [NPORT-1:0]   conn_fire;

  // named internal events
  logic               arb_hit;
  logic               par_ok;
  logic               bias_loss;
  logic               wd_fire;
  logic [NCAUSE-1:0]  hits;
  logic [CAUSE_W-1:0] enc_code;
  logic               any_trig;

  assign arb_hit   = |(port_arb_reset & port_connected);
  assign par_ok    = parent_valid && (int'(parent_port) < NPORT);
  assign bias_loss = par_ok && bias_q[parent_port] && !port_bias[parent_port];

  genvar gp;
  generate
    for (gp = 0; gp < NPORT; gp++) begin : g_conn
      brst_conn_delay #(.CONN_DLY(CONN_DLY)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .connected (port_connected[gp]),
        .cancel    (arb_hit),
        .fire      (conn_fire[gp])
      );
    end
  endgenerate

  brst_watchdog #(
    .SW(SW), .CLK_MHZ(CLK_MHZ), .WD_US(WD_US),
    .ST_IDLE(ST_IDLE), .ST_TSTART(ST_TSTART), .ST_TX(ST_TX), .ST_RX(ST_RX)
  ) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_state (arb_state),
    .wd_fire   (wd_fire)
  );

  assign hits = {wd_fire, |conn_fire, peer_suspend_evt, bias_loss,
                 resume_evt, link_reset_req, arb_hit, pwr_pend};

  brst_cause_pri u_pri (
    .hits    (hits),
    .code    (enc_code),
    .any_hit (any_trig)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_pend <= 1'b1;
      bias_q   <= '0;
    end else begin
      pwr_pend <= 1'b0;
      bias_q   <= port_bias;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_NORMAL;
      rcnt    <= '0;
      cause_q <= C_NONE;
    end else if (any_trig) begin
      ph_q    <= PH_RESET;
      rcnt    <= '0;
      cause_q <= enc_code;
    end else begin
      unique case (ph_q)
        PH_RESET: begin
          if (rcnt == RCW'(RESET_CYC - 1)) ph_q <= PH_TREE;
          else                             rcnt <= rcnt + 1'b1;
        end
        PH_TREE:   if (tree_done) ph_q <= PH_SELF;
        PH_SELF:   if (self_done) ph_q <= PH_NORMAL;
        default:   ph_q <= PH_NORMAL;
      endcase
    end
  end

  assign reset_drive = (ph_q == PH_RESET);
  assign phase       = ph_q;
  assign cause       = cause_q;

  // R11: any trigger restarts the reset phase on the next edge
  p_trig_enter_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    any_trig |=> (phase == 2'd1) && reset_drive);

  // R9: the recorded cause is the encoded winner of the trigger cycle
  p_cause_record_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    any_trig |=> cause == $past(enc_code));

  // R10: tree identification is only entered from the reset phase
  p_tree_entry_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && $past(phase) != 2'd2) |-> $past(phase) == 2'd1);

  // R10: self identification is only entered from tree identification
  p_self_entry_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && $past(phase) != 2'd3) |-> $past(phase) == 2'd2);

  // R2: an arbitration reset on a connected port is never lost
  p_arb_hit_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    arb_hit |=> reset_drive);

endmodule

// File: tb/tb_brst_trigger.sv
`timescale 1ns/1ps
module tb_brst_trigger;

  localparam int NPORT = 3;
  localparam int DLY   = 4;
  localparam int MHZ   = 2;
  localparam int US    = 5;
  localparam int LIM   = MHZ * US;
  localparam int RC    = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPORT-1:0] port_connected = '0;
  logic [NPORT-1:0] port_arb_reset = '0;
  logic [NPORT-1:0] port_bias = '1;
  logic             parent_valid = 1'b1;
  logic [1:0]       parent_port = 2'd1;
  logic             link_reset_req = 1'b0;
  logic             resume_evt = 1'b0;
  logic             peer_suspend_evt = 1'b0;
  logic [3:0]       arb_state = 4'd0;
  logic             tree_done = 1'b0;
  logic             self_done = 1'b0;
  logic             reset_drive;
  logic [1:0]       phase;
  logic [3:0]       cause;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  brst_trigger #(
    .NPORT(NPORT), .SW(4), .CONN_DLY(DLY), .CLK_MHZ(MHZ), .WD_US(US), .RESET_CYC(RC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .port_connected(port_connected),
    .port_arb_reset(port_arb_reset), .port_bias(port_bias),
    .parent_valid(parent_valid), .parent_port(parent_port),
    .link_reset_req(link_reset_req), .resume_evt(resume_evt),
    .peer_suspend_evt(peer_suspend_evt), .arb_state(arb_state),
    .tree_done(tree_done), .self_done(self_done),
    .reset_drive(reset_drive), .phase(phase), .cause(cause)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // from the first reset-phase cycle, walk the sequence back to normal (R10)
  task automatic finish_seq();
    chk("R10 drive in reset", int'(reset_drive), 1);
    step(RC - 1);
    chk("R10 reset length", int'(phase), 1);
    step(1);
    chk("R10 tree entry", int'(phase), 2);
    chk("R10 drive off", int'(reset_drive), 0);
    tree_done = 1'b1; step(1); tree_done = 1'b0;
    chk("R10 self entry", int'(phase), 3);
    self_done = 1'b1; step(1); self_done = 1'b0;
    chk("R10 normal", int'(phase), 0);
  endtask

  // drive direct cause codes 2..6
  task automatic set_src(input int code, input logic v);
    case (code)
      2: port_arb_reset[2] = v;
      3: link_reset_req = v;
      4: resume_evt = v;
      5: port_bias[1] = ~v;
      6: peer_suspend_evt = v;
      default: ;
    endcase
  endtask

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1: reset values
    chk("R1 drive in reset", int'(reset_drive), 0);
    chk("R1 phase in reset", int'(phase), 0);
    chk("R1 cause in reset", int'(cause), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 power phase", int'(phase), 1);
    chk("R1 power cause", int'(cause), 1);
    finish_seq();

    // R10: tree phase holds without tree_done
    link_reset_req = 1'b1; step(1); link_reset_req = 1'b0;
    chk("R3 link cause", int'(cause), 3);
    step(RC + 4);
    chk("R10 tree holds", int'(phase), 2);
    tree_done = 1'b1; step(1); tree_done = 1'b0;
    step(3);
    chk("R10 self holds", int'(phase), 3);
    self_done = 1'b1; step(1); self_done = 1'b0;
    chk("R10 back normal", int'(phase), 0);

    // R2: arbitration reset on an unconnected port is ignored
    port_arb_reset[0] = 1'b1; step(1); port_arb_reset[0] = 1'b0;
    step(1);
    chk("R2 unconnected ignored", int'(phase), 0);
    chk("R2 cause unchanged", int'(cause), 3);

    // R4, R6
    resume_evt = 1'b1; step(1); resume_evt = 1'b0;
    chk("R4 resume cause", int'(cause), 4);
    finish_seq();
    peer_suspend_evt = 1'b1; step(1); peer_suspend_evt = 1'b0;
    chk("R6 suspend cause", int'(cause), 6);
    finish_seq();

    // R7: connect delay on every port
    for (int p = 0; p < NPORT; p++) begin
      port_connected[p] = 1'b1;
      step(DLY);
      chk("R7 connect not early", int'(phase), 0);
      step(1);
      chk("R7 connect fires", int'(phase), 1);
      chk("R7 connect cause", int'(cause), 7);
      finish_seq();
    end

    // R2: connected port arbitration reset
    port_arb_reset[1] = 1'b1; step(1); port_arb_reset[1] = 1'b0;
    chk("R2 arb cause", int'(cause), 2);
    finish_seq();

    // R7: cancel of a pending connect by an incoming reset
    port_connected[0] = 1'b0; step(2);
    chk("R7 disconnect no reset", int'(phase), 0);
    port_connected[0] = 1'b1; step(2);
    port_arb_reset[1] = 1'b1; step(1); port_arb_reset[1] = 1'b0;
    chk("R7 cancel arb cause", int'(cause), 2);
    finish_seq();
    step(DLY + 2);
    chk("R7 cancelled stays normal", int'(phase), 0);
    chk("R7 cancelled cause", int'(cause), 2);

    // R7: disconnect while pending drops it
    port_connected[2] = 1'b0; step(2);
    port_connected[2] = 1'b1; step(DLY - 2);
    port_connected[2] = 1'b0; step(DLY + 2);
    chk("R7 drop while pending", int'(phase), 0);
    port_connected[2] = 1'b1;
    step(DLY + 1);
    chk("R7 reconnect fires", int'(cause), 7);
    finish_seq();

    // R5: bias loss
    port_bias[0] = 1'b0; step(2);
    chk("R5 non-parent ignored", int'(phase), 0);
    port_bias[0] = 1'b1; step(1);
    port_bias[1] = 1'b0; step(1); port_bias[1] = 1'b1;
    chk("R5 parent bias cause", int'(cause), 5);
    finish_seq();
    parent_valid = 1'b0;
    port_bias[1] = 1'b0; step(2);
    chk("R5 no parent ignored", int'(phase), 0);
    port_bias[1] = 1'b1; step(1);
    parent_valid = 1'b1; step(1);

    // R9: every pair of direct causes
    for (int a = 2; a <= 6; a++) begin
      for (int b = a + 1; b <= 6; b++) begin
        set_src(a, 1'b1); set_src(b, 1'b1);
        step(1);
        set_src(a, 1'b0); set_src(b, 1'b0);
        chk("R9 pair priority", int'(cause), a);
        finish_seq();
      end
    end
    // R9: three at once
    link_reset_req = 1'b1; resume_evt = 1'b1; peer_suspend_evt = 1'b1;
    step(1);
    link_reset_req = 1'b0; resume_evt = 1'b0; peer_suspend_evt = 1'b0;
    chk("R9 triple priority", int'(cause), 3);
    finish_seq();

    // R8: sweep every state code
    for (int s = 0; s < 16; s++) begin
      arb_state = 4'(s);
      if (s <= 3) begin
        step(2 * LIM + 2);
        chk("R8 exempt no reset", int'(phase), 0);
        arb_state = 4'd0; step(1);
      end else begin
        step(LIM);
        chk("R8 not before limit", int'(phase), 0);
        step(1);
        chk("R8 fires at limit", int'(phase), 1);
        chk("R8 watchdog cause", int'(cause), 8);
        arb_state = 4'd0;
        finish_seq();
      end
    end
    // R8: change of state restarts window
    arb_state = 4'd5; step(LIM - 1);
    arb_state = 4'd6; step(LIM);
    chk("R8 change restarts", int'(phase), 0);
    step(1);
    chk("R8 after restart", int'(cause), 8);
    arb_state = 4'd0;
    finish_seq();

    // R11: restart inside reset phase and from tree phase
    link_reset_req = 1'b1; step(1); link_reset_req = 1'b0;
    step(1);
    resume_evt = 1'b1; step(1); resume_evt = 1'b0;
    chk("R11 restart cause", int'(cause), 4);
    step(RC - 1);
    chk("R11 full length", int'(phase), 1);
    step(1);
    chk("R11 tree after restart", int'(phase), 2);
    peer_suspend_evt = 1'b1; step(1); peer_suspend_evt = 1'b0;
    chk("R11 tree to reset", int'(phase), 1);
    chk("R11 tree restart cause", int'(cause), 6);
    finish_seq();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule